// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a single PWM command into two mutually exclusive gate enables, one for a high-side switch and one for a low-side switch. It never relies on a fixed dead interval. Before it lets one side conduct, it first removes the drive from the opposite side. It then waits for that side's discharge sense flag to confirm that the gate has actually collapsed. Once the flag is confirmed, a short guard interval in clock cycles must also elapse before the new side is driven.

The two discharge flags are digitized comparator results. They are passed through a multi-stage synchronizer before the sequencer uses them. Both gates are held off whenever the enable input or the supply-good flag is low. If the PWM command reverses while a turn-on is still pending, that turn-on is abandoned and the sequence restarts toward the newly commanded side.

Top module: `gate_seq`

## Requirements
- R1: When the command moves to the low side (`pwm_hi` = 0) while `hi_on` is asserted, `hi_on` drops on the next clock edge. `lo_on` is never asserted in the cycle directly after a cycle in which `hi_on` was asserted.
- R2: `lo_on` asserts only while the synchronized high-side discharge flag is high (`hi_gate_dis` = 1 means discharged). While that flag stays low, `lo_on` stays low no matter how long the low side is commanded.
- R3: The guard interval requires the synchronized flag to stay high for GUARD_CYCLES consecutive cycles. If the flag drops before then, the count restarts. With the defaults (GUARD_CYCLES = 4, SYNC_STAGES = 2), a raw flag first sampled high at clock edge k gives an output that is high right after edge k+5. If the flag is already synchronized high, the output turns on 4 edges after the edge at which arming began.
- R4: High-side turn-on mirrors R1 to R3. The sequencer waits for the synchronized `lo_gate_dis` flag and the same guard interval, and only then asserts `hi_on`.
- R5: `hi_on` and `lo_on` are never both high.
- R6: While `enable` or `supply_ok` is low, both outputs are low in that same cycle. Afterwards the sequencer restarts from the idle state.
- R7: If `pwm_hi` reverses while a turn-on is pending, the pending turn-on is cancelled and the guard count is cleared. The turn-on toward the new side then starts afresh.
- R8: Synchronous active-high `rst` clears the state, the synchronizers and the guard count. Both outputs are low after an edge with `rst` high, even if a gate was on before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_hi | input | 1 | Command: 1 selects high side, 0 selects low side |
| enable | input | 1 | Channel enable |
| supply_ok | input | 1 | Supply above undervoltage threshold |
| hi_gate_dis | input | 1 | Raw flag, 1 = high-side gate discharged |
| lo_gate_dis | input | 1 | Raw flag, 1 = low-side gate discharged |
| hi_on | output | 1 | High-side gate enable |
| lo_on | output | 1 | Low-side gate enable |

## Verification
The assertions assume that every input is synchronous to `clk` and changes at most once per cycle. They also assume that `rst` is applied before the first meaningful edge. The turn-on assertions compare each rising gate enable with the synchronized flag seen at that edge, so they depend on the flag having been steady across that edge. The stimulus changes inputs only on the falling edge. It holds each discharge flag for whole cycles, and it starts every run under reset, so all these assumptions hold.

// File: rtl/gs_pkg.sv
package gs_pkg;

    typedef enum logic [2:0] {
        GS_IDLE,
        GS_ARM_LO,
        GS_LO_ON,
        GS_ARM_HI,
        GS_HI_ON
    } gs_state_e;

    typedef struct packed {
        logic hi_dis;
        logic lo_dis;
    } gs_sense_t;

    localparam int GS_SENSE_W = $bits(gs_sense_t);

    function automatic gs_state_e gs_arm_for(input logic want_hi);
        return want_hi ? GS_ARM_HI : GS_ARM_LO;
    endfunction

    function automatic logic gs_side_hi(input gs_state_e s);
        return (s == GS_ARM_HI) || (s == GS_HI_ON);
    endfunction

endpackage

// File: rtl/gs_sync.sv
module gs_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[LAST];

endmodule

// File: rtl/gs_guard.sv
module gs_guard #(
    parameter int GUARD = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic flag,
    output logic done
);
    localparam int          CW   = $clog2(GUARD + 1);
    localparam logic [CW-1:0] LAST = CW'(GUARD - 1);

    logic [CW-1:0] cnt;

    assign done = flag && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart || !flag)
            cnt <= '0;
        else if (!done)
            cnt <= cnt + CW'(1);
    end

    AST_GUARD_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST); // R3

    AST_GUARD_RESTART: assert property (@(posedge clk) disable iff (rst)
        (!flag || restart) |=> (cnt == '0)); // R3

endmodule

// File: rtl/gs_fsm.sv
module gs_fsm
    import gs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      active,
    input  logic      want_hi,
    input  gs_sense_t sense,
    input  logic      done,
    output logic      guard_flag,
    output logic      restart,
    output logic      hi_drv,
    output logic      lo_drv
);
    gs_state_e state, nxt;

    always_comb begin
        nxt = state;
        if (!active) begin
            nxt = GS_IDLE;
        end else begin
            unique case (state)
                GS_IDLE:   nxt = gs_arm_for(want_hi);
                GS_ARM_LO: if (want_hi) nxt = GS_ARM_HI;
                           else if (done) nxt = GS_LO_ON;
                GS_LO_ON:  if (want_hi) nxt = GS_ARM_HI;
                GS_ARM_HI: if (!want_hi) nxt = GS_ARM_LO;
                           else if (done) nxt = GS_HI_ON;
                GS_HI_ON:  if (!want_hi) nxt = GS_ARM_LO;
                default:   nxt = GS_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            GS_ARM_LO: guard_flag = sense.hi_dis;
            GS_ARM_HI: guard_flag = sense.lo_dis;
            default:   guard_flag = 1'b0;
        endcase
    end

    assign restart = (nxt != state);
    assign hi_drv  = (state == GS_HI_ON);
    assign lo_drv  = (state == GS_LO_ON);

    always_ff @(posedge clk) begin
        if (rst) state <= GS_IDLE;
        else     state <= nxt;
    end

    AST_CANCEL_TO_HI: assert property (@(posedge clk) disable iff (rst)
        (state == GS_ARM_LO && active && want_hi) |=> (state == GS_ARM_HI)); // R7

    AST_CANCEL_TO_LO: assert property (@(posedge clk) disable iff (rst)
        (state == GS_ARM_HI && active && !want_hi) |=> (state == GS_ARM_LO)); // R7

    AST_IDLE_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        !active |=> (state == GS_IDLE)); // R6

    AST_SIDE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && state != GS_IDLE) |-> (gs_side_hi(state) == $past(want_hi))); // R7

endmodule

// File: rtl/gate_seq.sv
module gate_seq
    import gs_pkg::*;
#(
    parameter int GUARD_CYCLES = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwm_hi,
    input  logic enable,
    input  logic supply_ok,
    input  logic hi_gate_dis,
    input  logic lo_gate_dis,
    output logic hi_on,
    output logic lo_on
);
    gs_sense_t sense_raw, sense_s;
    logic      active;
    logic      guard_flag, restart, done;
    logic      hi_drv, lo_drv;

    assign sense_raw.hi_dis = hi_gate_dis;
    assign sense_raw.lo_dis = lo_gate_dis;
    assign active           = enable && supply_ok;

    gs_sync #(.WIDTH(GS_SENSE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sense_raw),
        .q   (sense_s)
    );

    gs_guard #(.GUARD(GUARD_CYCLES)) u_guard (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .flag    (guard_flag),
        .done    (done)
    );

    gs_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .active     (active),
        .want_hi    (pwm_hi),
        .sense      (sense_s),
        .done       (done),
        .guard_flag (guard_flag),
        .restart    (restart),
        .hi_drv     (hi_drv),
        .lo_drv     (lo_drv)
    );

    assign hi_on = hi_drv && active;
    assign lo_on = lo_drv && active;

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(hi_on && lo_on)); // R5

    AST_LO_BREAK_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(lo_on) |-> !$past(hi_on)); // R1

    AST_LO_NEEDS_SENSE: assert property (@(posedge clk) disable iff (rst)
        $rose(lo_on) |-> $past(sense_s.hi_dis)); // R2

    AST_HI_NEEDS_SENSE: assert property (@(posedge clk) disable iff (rst)
        $rose(hi_on) |-> ($past(sense_s.lo_dis) && !$past(lo_on))); // R4

    AST_HI_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (hi_on && !pwm_hi) |=> !hi_on); // R1

endmodule

// File: tb/tb_gate_seq.sv
module tb_gate_seq;

    logic clk = 1'b0;
    logic rst, pwm_hi, enable, supply_ok, hi_gate_dis, lo_gate_dis;
    logic hi_on, lo_on;
    int   checks = 0;
    int   errors = 0;
    bit   done_run = 1'b0;

    always #5 clk = ~clk;

    gate_seq dut (
        .clk         (clk),
        .rst         (rst),
        .pwm_hi      (pwm_hi),
        .enable      (enable),
        .supply_ok   (supply_ok),
        .hi_gate_dis (hi_gate_dis),
        .lo_gate_dis (lo_gate_dis),
        .hi_on       (hi_on),
        .lo_on       (lo_on)
    );

    // bits: rst en sok pwm hd ld | exp_hi exp_lo
    localparam int NV = 37;
    localparam logic [7:0] VEC [NV] = '{
        8'b1000_0000, 8'b1000_0000,
        8'b0110_0000, 8'b0110_0000,
        8'b0110_1000, 8'b0110_1000, 8'b0110_1000, 8'b0110_1000, 8'b0110_1000,
        8'b0110_1001, 8'b0110_1001,
        8'b0111_0000,
        8'b0111_0100, 8'b0111_0100, 8'b0111_0100, 8'b0111_0100, 8'b0111_0100,
        8'b0111_0110, 8'b0111_0110,
        8'b0110_0100,
        8'b0110_1100, 8'b0110_1100, 8'b0110_1100,
        8'b0111_1100, 8'b0111_1100, 8'b0111_1100, 8'b0111_1100,
        8'b0111_1110, 8'b0111_1110,
        8'b0011_1100,
        8'b0111_1100, 8'b0111_1100, 8'b0111_1100, 8'b0111_1100,
        8'b0111_1110,
        8'b0101_1100, 8'b0101_1100
    };

    function automatic string req_of(input int i);
        if (i < 2)       return "R8";
        else if (i == 9) return "R3";
        else if (i < 11) return "R2";
        else if (i < 19) return "R4";
        else if (i == 19) return "R1";
        else if (i < 29) return "R7";
        else             return "R6";
    endfunction

    task automatic chk(input string req, input logic eh, input logic el);
        checks++;
        if (hi_on !== eh || lo_on !== el) begin
            errors++;
            $display("FAIL %s hi_on/lo_on actual=%b%b expected=%b%b at %0t",
                     req, hi_on, lo_on, eh, el, $time);
        end
        checks++;
        if (hi_on === 1'b1 && lo_on === 1'b1) begin
            errors++;
            $display("FAIL R5 overlap actual=11 expected=not 11 at %0t", $time);
        end
    endtask

    task automatic step(input logic r, input logic e, input logic s, input logic p,
                        input logic hd, input logic ld, input string req,
                        input logic eh, input logic el);
        @(negedge clk);
        rst = r; enable = e; supply_ok = s; pwm_hi = p;
        hi_gate_dis = hd; lo_gate_dis = ld;
        @(posedge clk);
        #1;
        chk(req, eh, el);
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_run) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog actual=timeout expected=completion");
            report();
        end
    end

    initial begin
        rst = 1'b1; enable = 1'b0; supply_ok = 1'b0; pwm_hi = 1'b0;
        hi_gate_dis = 1'b0; lo_gate_dis = 1'b0;

        // vector walk: R8 reset, R2/R3 low turn-on, R4 high turn-on,
        // R1 release, R7 cancel, R6 enable and supply gating
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4],
                 VEC[i][3], VEC[i][2], req_of(i), VEC[i][1], VEC[i][0]);
        end

        // R8: reset from idle
        step(1, 1, 1, 0, 0, 0, "R8", 0, 0);

        // R2: low side commanded, flag never high -> low gate stays off
        for (int k = 0; k < 12; k++) step(0, 1, 1, 0, 0, 0, "R2", 0, 0);

        // R3: a two-cycle flag pulse is shorter than the guard -> no turn-on
        step(0, 1, 1, 0, 1, 0, "R3", 0, 0);
        step(0, 1, 1, 0, 1, 0, "R3", 0, 0);
        for (int k = 0; k < 10; k++) step(0, 1, 1, 0, 0, 0, "R3", 0, 0);

        // R3: steady flag -> low gate on exactly 5 edges after first sample
        for (int k = 0; k < 6; k++) step(0, 1, 1, 0, 1, 0, "R3", 0, (k == 5));

        // R8: reset while the low gate is on
        step(1, 1, 1, 0, 1, 0, "R8", 0, 0);
        step(0, 1, 1, 0, 1, 0, "R8", 0, 0);
        step(0, 1, 1, 0, 1, 0, "R8", 0, 0);

        done_run = 1'b1;
        report();
    end

endmodule